// File: doc/BRIEF.md
# USB host transfer launch controller

This block sits between a byte-wide register bus and a serial interface engine that runs USB host transactions. It keeps two independent transfer banks. Each bank has a control byte and a buffer base-address byte. Software fills in a bank and sets its enable and arm bits. The block then decides when that transfer may go to the engine. It can wait for the engine to be idle, or for the next start-of-frame if the bank asks for that. When a launch happens, the block presents the direction, data toggle, isochronous flag, preamble request and buffer base address to the engine, and it holds them steady for the whole transfer.

The engine pulses done when a transfer finishes. That pulse goes only to the bank that owns the transfer in flight. The block clears that bank's arm bit, sets that bank's done status bit and raises the interrupt. Both banks share the one engine. A fixed tie-break and an alternating priority keep either bank from starving the other. While a bank's transfer is in flight, writes to that bank's base address are refused and reported as an error.

Top module: `usb_xfer_launch`

## Requirements
- R1: After reset every register reads 0x00 and all outputs (launch, preamble, fields, bank, irq, wr_err) are 0.
- R2: Register map on a 4-bit address: 0x0 is bank A control, 0x1 is bank A base, 0x8 is bank B control, 0x9 is bank B base, 0xE is status. Every other address reads 0x00. Control bit positions: 7 preamble, 6 data toggle, 5 sync-to-SOF, 4 isochronous, 3 reserved (stored only), 2 direction (1 = OUT), 1 enable, 0 arm. Status bits: 0 is bank A done, 1 is bank B done, 2 is base-write error.
- R3: A bank is launched only when its enable and arm bits are both 1, the engine is idle and no transfer is in flight. xfer_launch is a one-cycle pulse in the cycle after that condition is seen. A bank with enable at 0 is never launched.
- R4: A bank with sync-to-SOF set, at full speed, waits for an eng_sof pulse that arrives while the bank is already armed and enabled. It becomes eligible in the cycle after that pulse. When eng_low_speed is 1, sync-to-SOF has no effect.
- R5: xfer_preamble equals the preamble bit of the launched bank, forced to 0 when eng_low_speed is 1 at the launch decision.
- R6: At launch, xfer_out takes the direction bit, xfer_iso takes the isochronous bit, xfer_base takes the bank's base byte and xfer_bank takes the bank (0 = A, 1 = B). xfer_toggle takes the toggle bit only for OUT transfers and is 0 for IN transfers. All of these hold until the next launch.
- R7: An eng_done pulse during a transfer clears the owning bank's arm bit, and only that bank's arm bit. In the same edge it sets that bank's done status bit. irq is the OR of the two done bits.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R9: When both banks become eligible in the same cycle, bank A wins until the first completion. After each completion, priority goes to the bank that did not just complete.
- R10: A write to a bank's base register while that bank's transfer is in flight is ignored and sets the error status bit. wr_err shows that bit.
- R11: An eng_done pulse while no transfer is in flight has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| eng_idle | input | 1 | Engine free to accept a transfer |
| eng_sof | input | 1 | Pulse: start-of-frame has been sent |
| eng_low_speed | input | 1 | Engine runs in low-speed mode |
| eng_done | input | 1 | Pulse: current transfer finished |
| xfer_launch | output | 1 | Pulse: start the presented transfer |
| xfer_preamble | output | 1 | Send a preamble token first |
| xfer_out | output | 1 | 1 = OUT, 0 = IN |
| xfer_toggle | output | 1 | DATA1 when 1 (OUT only) |
| xfer_iso | output | 1 | Isochronous transfer |
| xfer_base | output | 8 | Buffer base address |
| xfer_bank | output | 1 | Launching bank, 0 = A, 1 = B |
| irq | output | 1 | Done interrupt |
| wr_err | output | 1 | Refused base-write error flag |

## Verification
The in-line assertions check on every cycle the behaviours that hold locally. Launch is a single-cycle pulse that follows an idle engine. Fields stay frozen while a transfer is in flight. No preamble is requested in low-speed mode. An IN transfer never carries a toggle. A done clears the owner's arm bit, and a refused base write leaves the base unchanged. Some behaviours are visible only as sequences that the bench's scenarios drive against its reference model: the wait for a start-of-frame, the alternation of priority between banks after completions, write-1-to-clear, and a stray done pulse having no effect.

// File: rtl/usb_launch_pkg.sv
package usb_launch_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int NBANK  = 2;

    localparam int B_ARM = 0;
    localparam int B_EN  = 1;
    localparam int B_DIR = 2;
    localparam int B_ISO = 4;
    localparam int B_SOF = 5;
    localparam int B_TOG = 6;
    localparam int B_PRE = 7;

    localparam logic [ADDR_W-1:0] A_CTRL_A = 4'h0;
    localparam logic [ADDR_W-1:0] A_BASE_A = 4'h1;
    localparam logic [ADDR_W-1:0] A_CTRL_B = 4'h8;
    localparam logic [ADDR_W-1:0] A_BASE_B = 4'h9;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'hE;

    localparam int S_DONE_A = 0;
    localparam int S_DONE_B = 1;
    localparam int S_ERR    = 2;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] base;
        logic              seen;
        logic              done;
        logic              err;
    } bank_st_t;

    typedef struct packed {
        logic              busy;
        logic              owner;
        logic              prio;
        logic              launch;
        logic              pre;
        logic              dir;
        logic              tog;
        logic              iso;
        logic [DATA_W-1:0] base;
    } arb_st_t;
endpackage

// File: rtl/usb_launch_bank.sv
module usb_launch_bank
    import usb_launch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_base,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr_done,
    input  logic              clr_err,
    input  logic              locked,
    input  logic              done_hit,
    input  logic              launched,
    input  logic              sof,
    input  logic              low_speed,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] base_o,
    output logic              elig_o,
    output logic              done_o,
    output logic              err_o
);
    bank_st_t st_d, st_q;
    logic     armed_en;
    logic     blocked;

    always_comb begin
        st_d     = st_q;
        armed_en = st_q.ctrl[B_EN] & st_q.ctrl[B_ARM];
        blocked  = wr_base & locked;

        if (wr_ctrl) st_d.ctrl = wdata;
        if (done_hit) st_d.ctrl[B_ARM] = 1'b0;

        if (wr_base && !locked) st_d.base = wdata;

        if (!armed_en || launched) st_d.seen = 1'b0;
        else if (sof)             st_d.seen = 1'b1;

        st_d.done = (st_q.done & ~clr_done) | done_hit;
        st_d.err  = (st_q.err & ~clr_err) | blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign base_o = st_q.base;
    assign elig_o = st_q.ctrl[B_EN] & st_q.ctrl[B_ARM] &
                    (~st_q.ctrl[B_SOF] | low_speed | st_q.seen);
    assign done_o = st_q.done;
    assign err_o  = st_q.err;

    assert_done_clears_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_hit && !wr_ctrl) |=> !st_q.ctrl[B_ARM]);

    assert_locked_base_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_base && locked) |=> $stable(st_q.base));
endmodule

// File: rtl/usb_launch_arb.sv
module usb_launch_arb
    import usb_launch_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NBANK-1:0]              elig,
    input  logic [NBANK-1:0][DATA_W-1:0]  ctrl,
    input  logic [NBANK-1:0][DATA_W-1:0]  base,
    input  logic                          eng_idle,
    input  logic                          eng_done,
    input  logic                          low_speed,
    output logic                          busy,
    output logic                          owner,
    output logic                          pick_vld,
    output logic                          pick,
    output logic                          launch,
    output logic                          pre,
    output logic                          dir,
    output logic                          tog,
    output logic                          iso,
    output logic [DATA_W-1:0]             base_o
);
    arb_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.launch = 1'b0;
        pick_vld    = !st_q.busy && eng_idle && (|elig);
        pick        = (&elig) ? st_q.prio : elig[1];

        if (st_q.busy && eng_done) begin
            st_d.busy = 1'b0;
            st_d.prio = ~st_q.owner;
        end

        if (pick_vld) begin
            st_d.busy   = 1'b1;
            st_d.owner  = pick;
            st_d.launch = 1'b1;
            st_d.pre    = ctrl[pick][B_PRE] & ~low_speed;
            st_d.dir    = ctrl[pick][B_DIR];
            st_d.tog    = ctrl[pick][B_DIR] & ctrl[pick][B_TOG];
            st_d.iso    = ctrl[pick][B_ISO];
            st_d.base   = base[pick];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign owner  = st_q.owner;
    assign launch = st_q.launch;
    assign pre    = st_q.pre;
    assign dir    = st_q.dir;
    assign tog    = st_q.tog;
    assign iso    = st_q.iso;
    assign base_o = st_q.base;

    assert_launch_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

    assert_launch_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(eng_idle));

    assert_fields_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !launch) |-> $stable({pre, dir, tog, iso, base_o, owner}));

    assert_in_has_no_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !dir) |-> !tog);

    assert_no_preamble_low_speed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !(pre && $past(low_speed)));
endmodule

// File: rtl/usb_xfer_launch.sv
module usb_xfer_launch
    import usb_launch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              eng_idle,
    input  logic              eng_sof,
    input  logic              eng_low_speed,
    input  logic              eng_done,
    output logic              xfer_launch,
    output logic              xfer_preamble,
    output logic              xfer_out,
    output logic              xfer_toggle,
    output logic              xfer_iso,
    output logic [7:0]        xfer_base,
    output logic              xfer_bank,
    output logic              irq,
    output logic              wr_err
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR [NBANK] = '{A_CTRL_A, A_CTRL_B};
    localparam logic [ADDR_W-1:0] BASE_ADDR [NBANK] = '{A_BASE_A, A_BASE_B};

    logic [NBANK-1:0][DATA_W-1:0] ctrl_w;
    logic [NBANK-1:0][DATA_W-1:0] base_w;
    logic [NBANK-1:0]             elig_w, done_w, err_w;
    logic                         busy_w, owner_w, pick_vld_w, pick_w;
    logic                         stat_wr;

    assign stat_wr = reg_we && (reg_addr == A_STAT);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic mine;
        assign mine = busy_w && (owner_w == b[0]);

        usb_launch_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl   (reg_we && (reg_addr == CTRL_ADDR[b])),
            .wr_base   (reg_we && (reg_addr == BASE_ADDR[b])),
            .wdata     (reg_wdata),
            .clr_done  (stat_wr && reg_wdata[b]),
            .clr_err   (stat_wr && reg_wdata[S_ERR]),
            .locked    (mine),
            .done_hit  (mine && eng_done),
            .launched  (pick_vld_w && (pick_w == b[0])),
            .sof       (eng_sof),
            .low_speed (eng_low_speed),
            .ctrl_o    (ctrl_w[b]),
            .base_o    (base_w[b]),
            .elig_o    (elig_w[b]),
            .done_o    (done_w[b]),
            .err_o     (err_w[b])
        );
    end

    usb_launch_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig_w),
        .ctrl      (ctrl_w),
        .base      (base_w),
        .eng_idle  (eng_idle),
        .eng_done  (eng_done),
        .low_speed (eng_low_speed),
        .busy      (busy_w),
        .owner     (owner_w),
        .pick_vld  (pick_vld_w),
        .pick      (pick_w),
        .launch    (xfer_launch),
        .pre       (xfer_preamble),
        .dir       (xfer_out),
        .tog       (xfer_toggle),
        .iso       (xfer_iso),
        .base_o    (xfer_base)
    );

    assign xfer_bank = owner_w;
    assign irq       = |done_w;
    assign wr_err    = |err_w;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL_A: reg_rdata = ctrl_w[0];
            A_BASE_A: reg_rdata = base_w[0];
            A_CTRL_B: reg_rdata = ctrl_w[1];
            A_BASE_B: reg_rdata = base_w[1];
            A_STAT: begin
                reg_rdata[S_DONE_A] = done_w[0];
                reg_rdata[S_DONE_B] = done_w[1];
                reg_rdata[S_ERR]    = |err_w;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/usb_xfer_launch_test.sv
module usb_xfer_launch_test;
    localparam int PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic reg_we = 0;
    logic [3:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic eng_idle = 1, eng_sof = 0, eng_low_speed = 0, eng_done = 0;
    logic xfer_launch, xfer_preamble, xfer_out, xfer_toggle, xfer_iso, xfer_bank, irq, wr_err;
    logic [7:0] xfer_base;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    usb_xfer_launch uut (.*);

    // Behavioural reference model
    logic [7:0] mctrl [2];
    logic [7:0] mbase [2];
    bit mseen [2], mdone [2], merr [2];
    bit mbusy, mown, mprio, mlaunch, mpre, mdir, mtog, miso;
    logic [7:0] mbaseo;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                mctrl[b] = 0; mbase[b] = 0; mseen[b] = 0; mdone[b] = 0; merr[b] = 0;
            end
            mbusy = 0; mown = 0; mprio = 0; mlaunch = 0; mpre = 0;
            mdir = 0; mtog = 0; miso = 0; mbaseo = 0;
        end else begin
            bit el [2];
            bit go, who, fin;
            logic [7:0] oc [2];
            for (int b = 0; b < 2; b++) begin
                oc[b] = mctrl[b];
                el[b] = mctrl[b][1] && mctrl[b][0] && (!mctrl[b][5] || eng_low_speed || mseen[b]);
            end
            go  = !mbusy && eng_idle && (el[0] || el[1]);
            who = (el[0] && el[1]) ? mprio : el[1];
            fin = mbusy && eng_done;
            for (int b = 0; b < 2; b++) begin
                bit own_b;
                own_b = mbusy && (mown == b);
                if (reg_we && reg_addr == (b ? 4'h8 : 4'h0)) mctrl[b] = reg_wdata;
                if (fin && own_b) mctrl[b][0] = 0;
                if (reg_we && reg_addr == (b ? 4'h9 : 4'h1)) begin
                    if (own_b) merr[b] = 1; else mbase[b] = reg_wdata;
                end
                if (!(oc[b][1] && oc[b][0]) || (go && who == b)) mseen[b] = 0;
                else if (eng_sof) mseen[b] = 1;
            end
            if (reg_we && reg_addr == 4'hE) begin
                if (reg_wdata[0]) mdone[0] = 0;
                if (reg_wdata[1]) mdone[1] = 0;
                if (reg_wdata[2]) begin
                    if (!(reg_we && reg_addr == (mown ? 4'h9 : 4'h1) && mbusy)) begin
                        merr[0] = 0; merr[1] = 0;
                    end else begin
                        merr[!mown] = 0;
                    end
                end
            end
            if (fin) begin mdone[mown] = 1; mbusy = 0; mprio = !mown; end
            mlaunch = 0;
            if (go) begin
                mbusy = 1; mown = who; mlaunch = 1;
                mpre = oc[who][7] && !eng_low_speed;
                mdir = oc[who][2]; mtog = oc[who][2] && oc[who][6];
                miso = oc[who][4]; mbaseo = mbase[who];
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mread(input logic [3:0] a);
        case (a)
            4'h0: return mctrl[0];
            4'h1: return mbase[0];
            4'h8: return mctrl[1];
            4'h9: return mbase[1];
            4'hE: return {5'b0, merr[0] | merr[1], mdone[1], mdone[0]};
            default: return 8'h00;
        endcase
    endfunction

    // Per-cycle comparison with the model, mid-cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 rdata", reg_rdata, mread(reg_addr));
            chk("R3 launch", {7'b0, xfer_launch}, {7'b0, mlaunch});
            chk("R5 preamble", {7'b0, xfer_preamble}, {7'b0, mpre});
            chk("R6 fields", {4'b0, xfer_out, xfer_toggle, xfer_iso, xfer_bank},
                {4'b0, mdir, mtog, miso, mown});
            chk("R6 base", xfer_base, mbaseo);
            chk("R7 irq", {7'b0, irq}, {7'b0, mdone[0] | mdone[1]});
            chk("R10 wr_err", {7'b0, wr_err}, {7'b0, merr[0] | merr[1]});
        end
    end

    task automatic step(); @(posedge clk); #1; endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        step(); reg_we = 1; reg_addr = a; reg_wdata = d;
        step(); reg_we = 0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
        step(); reg_addr = a; @(negedge clk); chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_done(); step(); eng_done = 1; step(); eng_done = 0; endtask
    task automatic pulse_sof();  step(); eng_sof = 1;  step(); eng_sof = 0;  endtask

    task automatic expect_launch(input string tag, input bit bank, input int maxc);
        bit seen = 0;
        for (int i = 0; i < maxc && !seen; i++) begin
            @(negedge clk);
            if (xfer_launch) begin
                seen = 1;
                chk(tag, {7'b0, xfer_bank}, {7'b0, bank});
            end
        end
        if (!seen) chk({tag, " no launch"}, 8'h00, 8'h01);
    endtask

    task automatic expect_quiet(input string tag, input int n);
        int cnt = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (xfer_launch) cnt++; end
        chk(tag, cnt[7:0], 8'h00);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset values
        @(negedge clk);
        chk("R1 launch", {7'b0, xfer_launch}, 8'h00);
        chk("R1 irq/err", {6'b0, irq, wr_err}, 8'h00);
        rd("R1 ctrl A", 4'h0, 8'h00);
        rd("R1 status", 4'hE, 8'h00);

        // R2 map, reserved bit stored, unmapped reads 0
        wr(4'h1, 8'h5A); wr(4'h9, 8'hC3); wr(4'h8, 8'h08);
        rd("R2 base A", 4'h1, 8'h5A);
        rd("R2 base B", 4'h9, 8'hC3);
        rd("R2 ctrl B reserved", 4'h8, 8'h08);
        rd("R2 unmapped", 4'h3, 8'h00);

        // R3 enable without arm / arm without enable does nothing
        wr(4'h0, 8'h02); expect_quiet("R3 enable only", 6);
        wr(4'h0, 8'h01); expect_quiet("R3 arm only", 6);

        // R3/R6 OUT with DATA1 on bank A
        wr(4'h0, 8'h47);
        expect_launch("R3 bank A launch", 0, 4);
        chk("R6 out", {7'b0, xfer_out}, 8'h01);
        chk("R6 toggle out", {7'b0, xfer_toggle}, 8'h01);
        chk("R6 base", xfer_base, 8'h5A);
        // R10 base write while in flight
        wr(4'h1, 8'h11);
        rd("R10 base kept", 4'h1, 8'h5A);
        chk("R10 err flag", {7'b0, wr_err}, 8'h01);
        // R7 done
        pulse_done();
        rd("R7 arm cleared", 4'h0, 8'h46);
        rd("R7 status", 4'hE, 8'h05);
        // R8 W1C
        wr(4'hE, 8'h04);
        rd("R8 err cleared", 4'hE, 8'h01);
        wr(4'hE, 8'h01);
        rd("R8 done cleared", 4'hE, 8'h00);
        // R11 stray done
        pulse_done();
        rd("R11 stray done", 4'hE, 8'h00);

        // R4 sync to SOF, IN with toggle set and iso on bank B
        wr(4'h8, 8'h73);
        expect_quiet("R4 waits for SOF", 8);
        pulse_sof();
        expect_launch("R4 after SOF", 1, 4);
        chk("R6 toggle IN zero", {7'b0, xfer_toggle}, 8'h00);
        chk("R6 iso", {7'b0, xfer_iso}, 8'h01);
        pulse_done();
        rd("R7 B done only", 4'hE, 8'h02);
        rd("R7 A ctrl untouched", 4'h0, 8'h46);
        wr(4'hE, 8'h02);

        // R4/R5 low speed: sync ignored, preamble suppressed
        step(); eng_low_speed = 1;
        wr(4'h0, 8'hA3);
        expect_launch("R4 low speed ignores sync", 0, 4);
        chk("R5 no preamble low speed", {7'b0, xfer_preamble}, 8'h00);
        pulse_done();
        step(); eng_low_speed = 0;
        wr(4'h0, 8'h83);
        expect_launch("R5 full speed launch", 0, 4);
        chk("R5 preamble", {7'b0, xfer_preamble}, 8'h01);
        pulse_done();
        wr(4'hE, 8'h07);

        // R9 tie: last completion was A, so B wins, then A
        step(); eng_idle = 0;
        wr(4'h0, 8'h03); wr(4'h8, 8'h07);
        step(); eng_idle = 1;
        expect_launch("R9 tie goes to B", 1, 4);
        pulse_done();
        expect_launch("R9 A follows", 0, 4);
        pulse_done();
        rd("R9 both done", 4'hE, 8'h03);
        repeat (3) step();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule